// File: doc/BRIEF.md
# Two-Register Stack Execution Unit

This block is the execute stage of a stack machine, together with the stack-pointer logic that sits one stage ahead of it. The two topmost stack elements are held in registers: A is the top of stack and B is the element under it. All deeper elements are kept in a small stack RAM. The RAM has one synchronous read port and one write port. Every instruction either pushes or pops, or leaves the stack alone. The unit spills B to the RAM on a push and refills B from the RAM on a pop. The instruction stream never has to manage the RAM.

The decode stage presents a stack operation, an ALU operation and a read-source select. On the clock edge that moves the instruction into execute, the unit does three things. It updates the stack pointer. It registers the spill address. For a pop, it starts the RAM read. The fill data therefore reaches execute in the same cycle as the instruction, so no stall is needed. No write-back stage exists and no forwarding path exists. A is driven straight out as the write data for external modules. A multiplexer chooses which external read-data port feeds A on a push.

Top module: `stack_exec_unit`

## Requirements
- R1: While rstN is low, tosA, nosB and stackPtr are all zero.
- R2: The stack operation encoding is 00 = none, 01 = push, 10 = pop. The code 11 is treated as none. A none instruction changes neither tosA, nosB nor stackPtr.
- R3: stackPtr changes on the edge that captures the decode controls. A push adds one and a pop subtracts one, modulo 2**PTR_W.
- R4: When a push executes, the old B is written to RAM at the incremented stack pointer, B takes the old A, and A takes the selected read data.
- R5: When a pop executes, A takes an ALU result. The ALU codes are 000 = A+B, 001 = B-A, 010 = A AND B, 011 = A OR B, 100 = A XOR B, and 101/110/111 = B (a plain drop of A).
- R6: A pop refills B from RAM at the stack pointer value held before the decrement. This holds even when the pop directly follows a push: the RAM read that coincides with the spill write returns the newly written value.
- R7: The tosA and nosB results of an instruction appear two rising edges after its controls are presented. Instructions can be issued on every cycle with no stall.
- R8: After more than 2**PTR_W net pushes, the oldest spilled entries are overwritten. Later pops return the RAM contents as they then stand, at the wrapped addresses.
- R9: dcdSrcSel = k loads the push value from srcData[k*DATA_W +: DATA_W]. This bus is sampled during the cycle in which the push executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dcdStackOp | input | 2 | Stack operation of the instruction in decode |
| dcdAluOp | input | 3 | ALU operation used when the instruction pops |
| dcdSrcSel | input | SEL_W | Read-data port that feeds A on a push |
| srcData | input | NUM_SRC*DATA_W | Read data of all external modules, packed |
| tosA | output | DATA_W | Top of stack, also the write data to external modules |
| nosB | output | DATA_W | Second stack element |
| stackPtr | output | PTR_W | Stack pointer, address of the topmost RAM entry |

## Verification
stackPtr is due one rising edge after the decode controls are presented. tosA and nosB are due two edges after. The read data for a push is due on the bus during the cycle in between.

The bench drives on falling edges and keeps a model of the stack in the same order as the instructions. At each falling edge it compares stackPtr with the model after the previous instruction, and tosA and nosB with the model after the instruction before that. It drives srcData one cycle behind the controls it belongs to. This lag puts back-to-back pushes and pops, the push-then-pop case that hits the RAM read-during-write, and the pointer wrap on exact cycle positions.

// File: rtl/stack_exec_pkg.sv
package stack_exec_pkg;

  localparam logic [1:0] SOP_NONE = 2'b00;
  localparam logic [1:0] SOP_PUSH = 2'b01;
  localparam logic [1:0] SOP_POP  = 2'b10;

  localparam logic [2:0] ALU_ADD = 3'd0;
  localparam logic [2:0] ALU_SUB = 3'd1;
  localparam logic [2:0] ALU_AND = 3'd2;
  localparam logic [2:0] ALU_OR  = 3'd3;
  localparam logic [2:0] ALU_XOR = 3'd4;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic       push;
    logic       pop;
    logic [2:0] aluOp;
  } exStrobe_t;

endpackage

// File: rtl/stack_exec_ctrl.sv
module stack_exec_ctrl
  import stack_exec_pkg::*;
#(
  parameter int PTR_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       dcdStackOp,
  input  logic [2:0]       dcdAluOp,
  input  logic [SEL_W-1:0] dcdSrcSel,
  output exStrobe_t        exStrobe,
  output logic [SEL_W-1:0] exSrcSel,
  output logic             ramRdEn,
  output logic [PTR_W-1:0] ramRdAddr,
  output logic [PTR_W-1:0] ramWrAddr,
  output logic [PTR_W-1:0] stackPtr
);

  logic             isPush;
  logic             isPop;
  logic [PTR_W-1:0] spNext;
  logic [PTR_W-1:0] spInc;

  assign isPush = (dcdStackOp == SOP_PUSH);
  assign isPop  = (dcdStackOp == SOP_POP);
  assign spInc  = stackPtr + 1'b1;

  always_comb begin
    spNext = stackPtr;
    if (isPush) begin
      spNext = spInc;
    end else if (isPop) begin
      spNext = stackPtr - 1'b1;
    end
  end

  // fill read is launched from decode with the current pointer
  assign ramRdEn   = isPop;
  assign ramRdAddr = stackPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr  <= '0;
      exStrobe  <= '0;
      exSrcSel  <= '0;
      ramWrAddr <= '0;
    end else begin
      stackPtr       <= spNext;
      exStrobe.push  <= isPush;
      exStrobe.pop   <= isPop;
      exStrobe.aluOp <= dcdAluOp;
      exSrcSel       <= dcdSrcSel;
      ramWrAddr      <= spInc;
    end
  end

endmodule

// File: rtl/stack_exec_ram.sv
module stack_exec_ram #(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [PTR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [PTR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  // write-first read port: a read that meets the spill write sees new data
  always_ff @(posedge clk) begin
    if (rdEn) begin
      if (wrEn && (wrAddr == rdAddr)) begin
        rdData <= wrData;
      end else begin
        rdData <= mem[rdAddr];
      end
    end
  end

endmodule

// File: rtl/stack_exec_dpath.sv
module stack_exec_dpath
  import stack_exec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  exStrobe_t                 exStrobe,
  input  logic [SEL_W-1:0]          exSrcSel,
  input  logic [NUM_SRC*DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0]         ramRdData,
  output logic [DATA_W-1:0]         tosA,
  output logic [DATA_W-1:0]         nosB,
  output logic                      spillEn,
  output logic [DATA_W-1:0]         spillData
);

  logic [DATA_W-1:0] srcArr [NUM_SRC];
  logic [DATA_W-1:0] srcPick;
  logic [DATA_W-1:0] aluRes;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign srcArr[g] = srcData[g*DATA_W +: DATA_W];
  end

  always_comb begin
    srcPick = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (exSrcSel == SEL_W'(i)) begin
        srcPick = srcArr[i];
      end
    end
  end

  always_comb begin
    case (exStrobe.aluOp)
      ALU_ADD: aluRes = tosA + nosB;
      ALU_SUB: aluRes = nosB - tosA;
      ALU_AND: aluRes = tosA & nosB;
      ALU_OR:  aluRes = tosA | nosB;
      ALU_XOR: aluRes = tosA ^ nosB;
      default: aluRes = nosB;
    endcase
  end

  assign spillEn   = exStrobe.push;
  assign spillData = nosB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tosA <= '0;
      nosB <= '0;
    end else if (exStrobe.push) begin
      tosA <= srcPick;
      nosB <= tosA;
    end else if (exStrobe.pop) begin
      tosA <= aluRes;
      nosB <= ramRdData;
    end
  end

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stack_exec_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int PTR_W   = 4,
  parameter  int NUM_SRC = 4,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                dcdStackOp,
  input  logic [2:0]                dcdAluOp,
  input  logic [SEL_W-1:0]          dcdSrcSel,
  input  logic [NUM_SRC*DATA_W-1:0] srcData,
  output logic [DATA_W-1:0]         tosA,
  output logic [DATA_W-1:0]         nosB,
  output logic [PTR_W-1:0]          stackPtr
);

  exStrobe_t         exStrobe;
  logic [SEL_W-1:0]  exSrcSel;
  logic              ramRdEn;
  logic [PTR_W-1:0]  ramRdAddr;
  logic [PTR_W-1:0]  ramWrAddr;
  logic              ramWrEn;
  logic [DATA_W-1:0] ramWrData;
  logic [DATA_W-1:0] ramRdData;

  stack_exec_ctrl #(.PTR_W(PTR_W), .SEL_W(SEL_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .dcdStackOp (dcdStackOp),
    .dcdAluOp   (dcdAluOp),
    .dcdSrcSel  (dcdSrcSel),
    .exStrobe   (exStrobe),
    .exSrcSel   (exSrcSel),
    .ramRdEn    (ramRdEn),
    .ramRdAddr  (ramRdAddr),
    .ramWrAddr  (ramWrAddr),
    .stackPtr   (stackPtr)
  );

  stack_exec_dpath #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .exStrobe  (exStrobe),
    .exSrcSel  (exSrcSel),
    .srcData   (srcData),
    .ramRdData (ramRdData),
    .tosA      (tosA),
    .nosB      (nosB),
    .spillEn   (ramWrEn),
    .spillData (ramWrData)
  );

  stack_exec_ram #(.DATA_W(DATA_W), .PTR_W(PTR_W)) ram_i (
    .clk    (clk),
    .wrEn   (ramWrEn),
    .wrAddr (ramWrAddr),
    .wrData (ramWrData),
    .rdEn   (ramRdEn),
    .rdAddr (ramRdAddr),
    .rdData (ramRdData)
  );

endmodule

// File: rtl/stack_exec_chk.sv
module stack_exec_chk
  import stack_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        dcdStackOp,
  input logic [DATA_W-1:0] tosA,
  input logic [DATA_W-1:0] nosB,
  input logic [PTR_W-1:0]  stackPtr,
  input exStrobe_t         exStrobe,
  input logic              ramWrEn,
  input logic [PTR_W-1:0]  ramWrAddr
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (tosA == '0 && nosB == '0 && stackPtr == '0)); // R1

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dcdStackOp == 2'b00 || dcdStackOp == 2'b11) |=> $stable(stackPtr)); // R2

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!exStrobe.push && !exStrobe.pop) |=> ($stable(tosA) && $stable(nosB))); // R2

  AST_SP_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (dcdStackOp == SOP_PUSH) |=> (stackPtr == PTR_W'($past(stackPtr) + 1'b1))); // R3

  AST_SP_POP: assert property (@(posedge clk) disable iff (!rstN)
    (dcdStackOp == SOP_POP) |=> (stackPtr == PTR_W'($past(stackPtr) - 1'b1))); // R3

  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    exStrobe.push |=> (nosB == $past(tosA))); // R4

  AST_SPILL_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    exStrobe.push |-> (ramWrEn && ramWrAddr == stackPtr)); // R4

endmodule

bind stack_exec_unit stack_exec_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .dcdStackOp (dcdStackOp),
  .tosA       (tosA),
  .nosB       (nosB),
  .stackPtr   (stackPtr),
  .exStrobe   (exStrobe),
  .ramWrEn    (ramWrEn),
  .ramWrAddr  (ramWrAddr)
);

// File: tb/stack_exec_unit_tb_top.sv
module stack_exec_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int PW   = 4;
  localparam int NSRC = 4;
  localparam int DEP  = 1 << PW;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  alu;
    logic [1:0]  sel;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 3'd0, 2'd0, 32'h0000_0011},  // push port0
    '{2'b01, 3'd0, 2'd1, 32'h0000_0022},  // push port1
    '{2'b01, 3'd0, 2'd2, 32'h0000_0033},  // push port2
    '{2'b10, 3'd0, 2'd0, 32'h0},          // pop add
    '{2'b01, 3'd0, 2'd3, 32'h0000_0044},  // push port3
    '{2'b10, 3'd1, 2'd0, 32'h0},          // pop sub, right after push
    '{2'b11, 3'd0, 2'd1, 32'hDEAD_BEEF},  // reserved op = none
    '{2'b00, 3'd2, 2'd2, 32'hCAFE_0000},  // none
    '{2'b01, 3'd0, 2'd0, 32'hF0F0_F0F0},
    '{2'b10, 3'd2, 2'd0, 32'h0},          // and
    '{2'b01, 3'd0, 2'd1, 32'h0F0F_1234},
    '{2'b10, 3'd3, 2'd0, 32'h0},          // or
    '{2'b01, 3'd0, 2'd2, 32'hFFFF_0000},
    '{2'b10, 3'd4, 2'd0, 32'h0},          // xor
    '{2'b01, 3'd0, 2'd3, 32'h0000_0005},
    '{2'b10, 3'd5, 2'd0, 32'h0},          // drop
    '{2'b01, 3'd0, 2'd0, 32'h0000_0007},
    '{2'b10, 3'd7, 2'd0, 32'h0},          // drop
    '{2'b01, 3'd0, 2'd1, 32'h1234_5678},
    '{2'b01, 3'd0, 2'd2, 32'h9ABC_DEF0},
    '{2'b10, 3'd1, 2'd0, 32'h0},          // sub
    '{2'b10, 3'd6, 2'd0, 32'h0}           // drop
  };
  localparam string VTAG [NV] = '{
    "R4", "R9", "R9", "R5", "R9", "R6", "R2", "R2", "R7", "R5", "R7",
    "R5", "R7", "R5", "R7", "R5", "R7", "R5", "R9", "R7", "R6", "R5"
  };

  logic                 clk = 1'b0;
  logic                 rstN;
  logic [1:0]           dcdStackOp;
  logic [2:0]           dcdAluOp;
  logic [1:0]           dcdSrcSel;
  logic [NSRC*DW-1:0]   srcData;
  logic [DW-1:0]        tosA;
  logic [DW-1:0]        nosB;
  logic [PW-1:0]        stackPtr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [DW-1:0] mA, mB;
  logic [PW-1:0] mSp;
  logic [DW-1:0] mMem [DEP];
  logic [DW-1:0] s2A, s2B;
  string         s1Tag, s2Tag;
  logic [1:0]    prevSel;
  logic [DW-1:0] prevVal;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_exec_unit #(.DATA_W(DW), .PTR_W(PW), .NUM_SRC(NSRC)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .dcdStackOp (dcdStackOp),
    .dcdAluOp   (dcdAluOp),
    .dcdSrcSel  (dcdSrcSel),
    .srcData    (srcData),
    .tosA       (tosA),
    .nosB       (nosB),
    .stackPtr   (stackPtr)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] aluRef(input logic [2:0] op,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    case (op)
      3'd0:    return a + b;
      3'd1:    return b - a;
      3'd2:    return a & b;
      3'd3:    return a | b;
      3'd4:    return a ^ b;
      default: return b;
    endcase
  endfunction

  // one instruction per falling edge; results checked with their latency
  task automatic issue(input logic [1:0] op, input logic [2:0] alu,
                       input logic [1:0] sel, input logic [DW-1:0] val,
                       input string tag);
    @(negedge clk);
    check(s2Tag, "tosA", tosA, s2A);
    check(s2Tag, "nosB", nosB, s2B);
    check(s1Tag, "stackPtr", DW'(stackPtr), DW'(mSp));
    for (int p = 0; p < NSRC; p++) begin
      srcData[p*DW +: DW] = (p == int'(prevSel)) ? prevVal
                                                 : (prevVal ^ (32'hA5A5_0101 * (p + 1)));
    end
    dcdStackOp = op;
    dcdAluOp   = alu;
    dcdSrcSel  = sel;
    prevSel = sel;
    prevVal = val;
    s2A = mA;
    s2B = mB;
    s2Tag = s1Tag;
    if (op == 2'b01) begin
      mMem[mSp + 1'b1] = mB;
      mSp = mSp + 1'b1;
      mB = mA;
      mA = val;
    end else if (op == 2'b10) begin
      mA = aluRef(alu, mA, mB);
      mB = mMem[mSp];
      mSp = mSp - 1'b1;
    end
    s1Tag = tag;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    dcdStackOp = 2'b00;
    @(negedge clk);
    @(negedge clk);
    check("R1", "tosA", tosA, '0);
    check("R1", "nosB", nosB, '0);
    check("R1", "stackPtr", DW'(stackPtr), '0);
    rstN = 1'b1;
    mA = '0; mB = '0; mSp = '0;
    s2A = '0; s2B = '0;
    s1Tag = "R1"; s2Tag = "R1";
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    dcdStackOp = 2'b00;
    dcdAluOp = 3'd0;
    dcdSrcSel = 2'd0;
    srcData = '0;
    prevSel = 2'd0;
    prevVal = '0;
    for (int i = 0; i < DEP; i++) mMem[i] = 'x;
    doReset();

    // table walk: pushes, pops, ALU codes, source ports, back-to-back
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].op, VEC[v].alu, VEC[v].sel, VEC[v].val, VTAG[v]);
    end
    issue(2'b00, 3'd0, 2'd0, '0, "R2");
    issue(2'b00, 3'd0, 2'd0, '0, "R2");

    // R8: pointer wraps; more pushes than RAM entries, then deep pops
    for (int i = 0; i < DEP + 4; i++) begin
      issue(2'b01, 3'd0, 2'(i % NSRC), 32'h0000_0100 + i, "R8");
    end
    for (int i = 0; i < DEP + 6; i++) begin
      issue(2'b10, 3'(5 + (i % 3)), 2'd0, '0, "R8");
    end
    // push/pop alternating each cycle through the wrapped pointer
    for (int i = 0; i < 6; i++) begin
      issue(2'b01, 3'd0, 2'd3, 32'h5000_0000 + i, "R6");
      issue(2'b10, 3'd0, 2'd0, '0, "R6");
    end
    issue(2'b00, 3'd0, 2'd0, '0, "R2");
    issue(2'b00, 3'd0, 2'd0, '0, "R2");

    // reset in mid-run clears the registers; RAM keeps its contents
    doReset();
    issue(2'b01, 3'd0, 2'd2, 32'hABCD_0001, "R4");
    issue(2'b01, 3'd0, 2'd1, 32'hABCD_0002, "R4");
    issue(2'b10, 3'd1, 2'd0, '0, "R3");
    issue(2'b10, 3'd0, 2'd0, '0, "R3");
    issue(2'b00, 3'd0, 2'd0, '0, "R2");
    issue(2'b00, 3'd0, 2'd0, '0, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule